// File: doc/BRIEF.md
# Pipelined Shift-and-Add Floating-Point Divider

This block divides two single-precision binary floating-point numbers, Q = Y / X. It does not use a digit-recurrence or multiplicative divider. It forms the reciprocal of the divisor with a chain of linear-mode CORDIC micro-steps, and then multiplies the dividend by that reciprocal.

Linear CORDIC converges only when the reciprocal stays below two in magnitude. The front stage therefore rescales the divisor before the iterations. The divisor keeps its 24-bit significand, and its exponent field is clamped into 126 or 127, which places the scaled divisor in [0.5, 2). The number of binades removed is carried forward as a credit. After the iterations, the fixed-point reciprocal is normalised. The credit is then returned to its exponent, with the sign of the divisor attached. A final 24x24 significand product, renormalisation and truncation give the quotient.

The datapath is fully pipelined. It accepts one operand pair per clock, marked by `i_valid`, and delivers each quotient a fixed number of cycles later with `o_valid`. Results that overflow or underflow the normal range are saturated and flagged. A zero divisor is also flagged. Operands are assumed to be normal numbers, apart from the zero cases named below.

Top module: `cordic_fdiv`

## Requirements
- R1: For normal operands whose true quotient is a normal number, the result is within a relative error of 2^-16 of Y/X, and all three flags stay low.
- R2: A pair sampled with `i_valid` high on a rising edge gives `o_valid` high after the ITER+2nd following rising edge, that is ITER+3 register stages in all. Pairs offered on consecutive cycles come out on consecutive cycles, in the same order.
- R3: Range reduction:
  - A divisor exponent field below 126 is raised to 126, and the difference is added to the reciprocal exponent.
  - A field above 127 is lowered to 127, and the difference is subtracted.
  - Fields 126 and 127 pass through unchanged.
  - R1 holds for every divisor exponent field from 1 to 254, including the smallest and the largest.
- R4: Dividing 500.0 (0x43FA0000) by 180.0 (0x43340000) gives a result with exponent field 128 (bits 30:23) whose value is within R1 of 2.77778.
- R5: Bit 31 of every result is the XOR of bit 31 of the two operands, including zero and infinite results.
- R6: If the quotient's biased exponent would be 255 or more, `o_quo[30:0]` is 0x7F800000 (infinity) and `o_ovf` is high.
- R7: If the quotient's biased exponent would be 0 or less, `o_quo[30:0]` is zero and `o_unf` is high.
- R8: If bits 30:0 of the divisor are all zero, the result is infinity and `o_dz` is high, with `o_ovf` and `o_unf` low. This takes priority over a zero dividend.
- R9: A dividend with exponent field 0, divided by a nonzero divisor, gives a signed zero with all flags low.
- R10: While reset is asserted, and after its release until the first result, `o_valid`, `o_quo`, `o_ovf`, `o_unf` and `o_dz` are all zero.
- R11: Only the final quotient exponent is range-checked. A reciprocal that alone falls outside the normal range (for example divisor 2^127) still gives a correct quotient when the dividend brings it back.
- R12: At most one of `o_ovf`, `o_unf` and `o_dz` is high at a time, and each is high only together with `o_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_valid | input | 1 | Operand pair present this cycle |
| i_dvd | input | 32 | Dividend Y, single-precision |
| i_dvs | input | 32 | Divisor X, single-precision |
| o_valid | output | 1 | Quotient present this cycle |
| o_quo | output | 32 | Quotient Q, single-precision |
| o_ovf | output | 1 | Quotient saturated to infinity |
| o_unf | output | 1 | Quotient flushed to zero |
| o_dz | output | 1 | Divisor was zero |

## Verification
A table of hand-picked pairs exercises the divisor in each of its three reduction cases:
- below the window, at exponent fields 126 and 127, and above the window;
- a significand of exactly one, where the reciprocal reaches its ceiling of two;
- every sign combination.

This separates a credit applied in the wrong direction or off by one from a fault in the iterations themselves. A second stream ramps the divisor up and the dividend down across about 0.06 to 500 on consecutive cycles, which exposes stage-to-stage payload skew and ordering faults. Directed pairs at the exponent extremes separate saturation that is decided too early, on the reciprocal, from saturation decided correctly, on the product. They also check overflow, underflow, zero divisor and zero dividend with each sign.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int EBIAS  = 127;
    localparam int EWIN_LO = 126;
    localparam int EWIN_HI = 127;

    // Operand payload travelling beside the reciprocal iterations.
    typedef struct packed {
        logic        vld;
        logic        sgn;      // quotient sign (dividend sign xor divisor sign)
        logic [7:0]  ey;       // dividend exponent field
        logic [22:0] my;       // dividend fraction
        logic        cred_up;  // 1: divisor was scaled up, credit is added back
        logic [7:0]  cred;     // credit magnitude in binades
        logic        nul;      // dividend exponent field is zero
        logic        dz;       // divisor is zero
    } cdiv_pay_t;

endpackage

// File: rtl/cdiv_detect.sv
module cdiv_detect
    import cdiv_pkg::*;
#(
    parameter int FB = 28,
    parameter int W  = FB + 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        i_valid,
    input  logic [31:0] i_dvd,
    input  logic [31:0] i_dvs,
    output cdiv_pay_t   o_pay,
    output logic [W-1:0] o_x
);

    localparam int SH_HI = FB - 23;   // significand placed for a value in [1,2)
    localparam int SH_LO = FB - 24;   // significand placed for a value in [0.5,1)

    typedef struct packed {
        cdiv_pay_t      pay;
        logic [W-1:0]   x;
    } det_t;

    det_t        st_d, st_q;
    logic [7:0]  ex, ex0;
    logic [23:0] mx;

    always_comb begin : p_detect
        ex  = i_dvs[30:23];
        mx  = {1'b1, i_dvs[22:0]};
        st_d = '0;
        st_d.pay.vld = i_valid;
        st_d.pay.sgn = i_dvd[31] ^ i_dvs[31];
        st_d.pay.ey  = i_dvd[30:23];
        st_d.pay.my  = i_dvd[22:0];
        st_d.pay.nul = (i_dvd[30:23] == 8'd0);
        st_d.pay.dz  = (i_dvs[30:0] == 31'd0);
        if (ex < 8'(EWIN_LO)) begin
            st_d.pay.cred_up = 1'b1;
            st_d.pay.cred    = 8'(EWIN_LO) - ex;
            ex0              = 8'(EWIN_LO);
        end else if (ex > 8'(EWIN_HI)) begin
            st_d.pay.cred_up = 1'b0;
            st_d.pay.cred    = ex - 8'(EWIN_HI);
            ex0              = 8'(EWIN_HI);
        end else begin
            st_d.pay.cred_up = 1'b0;
            st_d.pay.cred    = 8'd0;
            ex0              = ex;
        end
        if (ex0 == 8'(EWIN_HI)) begin
            st_d.x = W'(mx) << SH_HI;
        end else begin
            st_d.x = W'(mx) << SH_LO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_pay = st_q.pay;
    assign o_x   = st_q.x;

endmodule

// File: rtl/cdiv_step.sv
module cdiv_step
    import cdiv_pkg::*;
#(
    parameter int FB = 28,
    parameter int W  = FB + 3,
    parameter int SH = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cdiv_pay_t    i_pay,
    input  logic [W-1:0] i_x,
    input  logic [W-1:0] i_y,
    input  logic [W-1:0] i_z,
    output cdiv_pay_t    o_pay,
    output logic [W-1:0] o_x,
    output logic [W-1:0] o_y,
    output logic [W-1:0] o_z
);

    localparam logic [W-1:0] WEIGHT = (W'(1) << FB) >> SH;

    typedef struct packed {
        cdiv_pay_t    pay;
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] z;
    } stp_t;

    stp_t         st_d, st_q;
    logic [W-1:0] xs;

    always_comb begin : p_step
        xs       = i_x >> SH;          // divisor is positive here
        st_d.pay = i_pay;
        st_d.x   = i_x;
        if (i_y[W-1]) begin            // residual negative: step up
            st_d.y = i_y + xs;
            st_d.z = i_z - WEIGHT;
        end else begin                 // residual non-negative: step down
            st_d.y = i_y - xs;
            st_d.z = i_z + WEIGHT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_pay = st_q.pay;
    assign o_x   = st_q.x;
    assign o_y   = st_q.y;
    assign o_z   = st_q.z;

endmodule

// File: rtl/cdiv_recip.sv
module cdiv_recip
    import cdiv_pkg::*;
#(
    parameter int ITER = 24,
    parameter int FB   = ITER + 4,
    parameter int W    = FB + 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cdiv_pay_t    i_pay,
    input  logic [W-1:0] i_x,
    output cdiv_pay_t    o_pay,
    output logic [W-1:0] o_z
);

    localparam logic [W-1:0] UNIT = W'(1) << FB;

    cdiv_pay_t    pay_w [ITER+1];
    logic [W-1:0] x_w   [ITER+1];
    logic [W-1:0] y_w   [ITER+1];
    logic [W-1:0] z_w   [ITER+1];
    logic         unused_tail;

    assign pay_w[0] = i_pay;
    assign x_w[0]   = i_x;
    assign y_w[0]   = UNIT;
    assign z_w[0]   = '0;

    generate
        for (genvar g = 0; g < ITER; g++) begin : g_step
            cdiv_step #(.FB(FB), .W(W), .SH(g)) u_step (
                .clk   (clk),
                .rst_n (rst_n),
                .i_pay (pay_w[g]),
                .i_x   (x_w[g]),
                .i_y   (y_w[g]),
                .i_z   (z_w[g]),
                .o_pay (pay_w[g+1]),
                .o_x   (x_w[g+1]),
                .o_y   (y_w[g+1]),
                .o_z   (z_w[g+1])
            );
        end
    endgenerate

    assign o_pay       = pay_w[ITER];
    assign o_z         = z_w[ITER];
    assign unused_tail = ^{x_w[ITER], y_w[ITER]};

endmodule

// File: rtl/cdiv_finish.sv
module cdiv_finish
    import cdiv_pkg::*;
#(
    parameter int FB = 28,
    parameter int W  = FB + 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cdiv_pay_t    i_pay,
    input  logic [W-1:0] i_z,
    output logic         o_valid,
    output logic [31:0]  o_quo,
    output logic         o_ovf,
    output logic         o_unf,
    output logic         o_dz
);

    typedef struct packed {
        cdiv_pay_t          pay;
        logic [22:0]        mz;
        logic signed [11:0] ez;
    } aln_t;

    typedef struct packed {
        logic        vld;
        logic [31:0] q;
        logic        ovf;
        logic        unf;
        logic        dz;
    } res_t;

    aln_t               a_d, a_q;
    res_t               r_d, r_q;
    logic signed [11:0] eu, cr;
    logic [47:0]        prod;
    logic signed [11:0] qe;
    logic [22:0]        qm;
    logic               unused_bits;

    // Stage A: normalise the fixed-point reciprocal and return the credit.
    always_comb begin : p_align
        a_d     = '0;
        a_d.pay = i_pay;
        if (i_z[FB+1]) begin
            a_d.mz = i_z[FB:FB-22];
            eu     = 12'sd1;
        end else if (i_z[FB]) begin
            a_d.mz = i_z[FB-1:FB-23];
            eu     = 12'sd0;
        end else begin
            a_d.mz = i_z[FB-2:FB-24];
            eu     = -12'sd1;
        end
        cr     = $signed({4'b0000, i_pay.cred});
        a_d.ez = 12'(EBIAS) + eu + (i_pay.cred_up ? cr : -cr);
    end

    // Stage B: significand product, renormalise, truncate, saturate.
    always_comb begin : p_mul
        prod = 48'({1'b1, a_q.pay.my}) * 48'({1'b1, a_q.mz});
        qe   = $signed({4'b0000, a_q.pay.ey}) + a_q.ez - 12'(EBIAS)
               + (prod[47] ? 12'sd1 : 12'sd0);
        qm   = prod[47] ? prod[46:24] : prod[45:23];
        r_d  = '0;
        if (a_q.pay.vld) begin
            r_d.vld   = 1'b1;
            r_d.q[31] = a_q.pay.sgn;
            if (a_q.pay.dz) begin
                r_d.dz       = 1'b1;
                r_d.q[30:23] = 8'hFF;
            end else if (a_q.pay.nul) begin
                r_d.q[30:0] = '0;
            end else if (qe >= 12'sd255) begin
                r_d.ovf      = 1'b1;
                r_d.q[30:23] = 8'hFF;
            end else if (qe <= 12'sd0) begin
                r_d.unf = 1'b1;
            end else begin
                r_d.q[30:23] = qe[7:0];
                r_d.q[22:0]  = qm;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            r_q <= '0;
        end else begin
            a_q <= a_d;
            r_q <= r_d;
        end
    end

    assign o_valid     = r_q.vld;
    assign o_quo       = r_q.q;
    assign o_ovf       = r_q.ovf;
    assign o_unf       = r_q.unf;
    assign o_dz        = r_q.dz;
    assign unused_bits = ^{i_z[W-1], i_z[FB-25:0], prod[22:0], qe[11:8]};

endmodule

// File: rtl/cordic_fdiv.sv
module cordic_fdiv
    import cdiv_pkg::*;
#(
    parameter int ITER = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        i_valid,
    input  logic [31:0] i_dvd,
    input  logic [31:0] i_dvs,
    output logic        o_valid,
    output logic [31:0] o_quo,
    output logic        o_ovf,
    output logic        o_unf,
    output logic        o_dz
);

    localparam int FB = ITER + 4;   // fraction bits of the reciprocal datapath
    localparam int W  = FB + 3;     // sign plus two integer bits

    cdiv_pay_t    det_pay, rcp_pay;
    logic [W-1:0] det_x, rcp_z;

    cdiv_detect #(.FB(FB), .W(W)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_valid (i_valid),
        .i_dvd   (i_dvd),
        .i_dvs   (i_dvs),
        .o_pay   (det_pay),
        .o_x     (det_x)
    );

    cdiv_recip #(.ITER(ITER), .FB(FB), .W(W)) u_recip (
        .clk   (clk),
        .rst_n (rst_n),
        .i_pay (det_pay),
        .i_x   (det_x),
        .o_pay (rcp_pay),
        .o_z   (rcp_z)
    );

    cdiv_finish #(.FB(FB), .W(W)) u_finish (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_pay   (rcp_pay),
        .i_z     (rcp_z),
        .o_valid (o_valid),
        .o_quo   (o_quo),
        .o_ovf   (o_ovf),
        .o_unf   (o_unf),
        .o_dz    (o_dz)
    );

endmodule

// File: rtl/cordic_fdiv_chk.sv
module cordic_fdiv_chk #(
    parameter int LAT = 27
) (
    input logic        clk,
    input logic        rst_n,
    input logic        i_valid,
    input logic [31:0] i_dvd,
    input logic [31:0] i_dvs,
    input logic        o_valid,
    input logic [31:0] o_quo,
    input logic        o_ovf,
    input logic        o_unf,
    input logic        o_dz
);

    // Window checks done with shift registers instead of deep $past.
    logic [LAT-1:0] vpipe, spipe, zpipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpipe <= '0;
            spipe <= '0;
            zpipe <= '0;
        end else begin
            vpipe <= {vpipe[LAT-2:0], i_valid};
            spipe <= {spipe[LAT-2:0], i_dvd[31] ^ i_dvs[31]};
            zpipe <= {zpipe[LAT-2:0], i_dvs[30:0] == 31'd0};
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid == vpipe[LAT-1]);

    assert_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> o_quo[31] == spipe[LAT-1]);

    assert_ovf_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        o_ovf |-> o_quo[30:0] == 31'h7F800000);

    assert_unf_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        o_unf |-> o_quo[30:0] == 31'd0);

    assert_dz_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> o_dz == zpipe[LAT-1]);

    assert_dz_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        o_dz |-> o_quo[30:0] == 31'h7F800000);

    assert_flag_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_ovf, o_unf, o_dz}));

    assert_flag_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (o_ovf || o_unf || o_dz) |-> o_valid);

endmodule

bind cordic_fdiv cordic_fdiv_chk #(.LAT(ITER + 3)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_valid (i_valid),
    .i_dvd   (i_dvd),
    .i_dvs   (i_dvs),
    .o_valid (o_valid),
    .o_quo   (o_quo),
    .o_ovf   (o_ovf),
    .o_unf   (o_unf),
    .o_dz    (o_dz)
);

// File: tb/cordic_fdiv_bench.sv
module cordic_fdiv_bench;

    localparam int  ITER = 24;
    localparam int  LAT  = ITER + 3;
    localparam real TOL  = 1.0 / 65536.0;
    localparam int  NTBL = 16;
    localparam int  NRMP = 40;

    // {dividend, divisor}
    localparam logic [63:0] TBL [NTBL] = '{
        64'h43FA0000_43340000,  // 500 / 180
        64'h3F800000_40400000,  // 1 / 3
        64'h3F800000_3DCCCCCD,  // 1 / 0.1     (divisor below window)
        64'h3DCCCCCD_43FA0000,  // 0.1 / 500   (divisor above window)
        64'h40E00000_3F400000,  // 7 / 0.75    (field 126)
        64'h41200000_3FC00000,  // 10 / 1.5    (field 127)
        64'h40490FDB_3F000000,  // pi / 0.5    (reciprocal at ceiling)
        64'h42C80000_3F800000,  // 100 / 1
        64'hC0000000_40400000,  // -2 / 3
        64'h41480000_BE800000,  // 12.5 / -0.25
        64'hC3340000_C2040000,  // -180 / -33
        64'h437A0000_43050000,  // 250 / 133
        64'h3E99999A_3E4CCCCD,  // 0.3 / 0.2
        64'h3FC00000_43FA0000,  // 1.5 / 500
        64'h42040000_3E99999A,  // 33 / 0.3
        64'h3E800000_40E00000   // 0.25 / 7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_valid = 1'b0;
    logic [31:0] i_dvd = '0;
    logic [31:0] i_dvs = '0;
    logic        o_valid;
    logic [31:0] o_quo;
    logic        o_ovf, o_unf, o_dz;

    always #5 clk = ~clk;

    cordic_fdiv #(.ITER(ITER)) u_cordic_fdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_valid (i_valid),
        .i_dvd   (i_dvd),
        .i_dvs   (i_dvs),
        .o_valid (o_valid),
        .o_quo   (o_quo),
        .o_ovf   (o_ovf),
        .o_unf   (o_unf),
        .o_dz    (o_dz)
    );

    int          n_tot = 0;
    int          n_bad = 0;
    bit          fin = 1'b0;
    logic [34:0] rec [128];
    int          rec_n = 0;
    logic [31:0] sa [128];
    logic [31:0] sb [128];
    logic [34:0] res;

    always @(negedge clk) begin
        if (o_valid && rec_n < 128) begin
            rec[rec_n] = {o_ovf, o_unf, o_dz, o_quo};
            rec_n = rec_n + 1;
        end
    end

    function automatic real f2r(input logic [31:0] v);
        real m;
        m = (1.0 + real'(v[22:0]) / 8388608.0) * (2.0 ** (real'(int'(v[30:23])) - 127.0));
        return v[31] ? -m : m;
    endfunction

    task automatic tally(input bit ok, input string req, input string what,
                         input logic [34:0] act, input logic [34:0] exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Quotient accuracy, sign and clear flags for a normal result.
    task automatic chk_quo(input logic [31:0] a, input logic [31:0] b,
                           input logic [34:0] r, input string req);
        real e, g, rel;
        bit  ok;
        e   = f2r(a) / f2r(b);
        g   = f2r(r[31:0]);
        rel = (g - e) / e;
        if (rel < 0.0) rel = -rel;
        ok  = (r[34:32] == 3'b000) && (r[31] == (a[31] ^ b[31])) && (rel <= TOL);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %h/%h: got %h (%g, flags %b) expected %g", req, a, b,
                     r[31:0], g, r[34:32], e);
        end
    endtask

    task automatic issue1(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        i_valid = 1'b1;
        i_dvd   = a;
        i_dvs   = b;
        @(negedge clk);
        i_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        res = {o_ovf, o_unf, o_dz, o_quo};
        tally(o_valid, "R2", "o_valid at fixed latency", {34'd0, o_valid}, 35'd1);
    endtask

    task automatic stream(input int n, input string req);
        rec_n = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            i_valid = 1'b1;
            i_dvd   = sa[i];
            i_dvs   = sb[i];
        end
        @(negedge clk);
        i_valid = 1'b0;
        for (int w = 0; w < LAT + 8 && rec_n < n; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        tally(rec_n == n, "R2", "result count of back-to-back stream",
              35'(rec_n), 35'(n));
        for (int i = 0; i < n && i < rec_n; i++) chk_quo(sa[i], sb[i], rec[i], req);
    endtask

    initial begin : p_watchdog
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_tot++;
            n_bad++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin : p_main
        int lat;
        // R10: outputs quiet in and after reset
        repeat (3) @(negedge clk);
        tally({o_valid, o_ovf, o_unf, o_dz, o_quo} == 36'd0, "R10", "outputs in reset",
              {o_ovf, o_unf, o_dz, o_quo}, 35'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        tally({o_valid, o_ovf, o_unf, o_dz, o_quo} == 36'd0, "R10", "outputs after reset",
              {o_ovf, o_unf, o_dz, o_quo}, 35'd0);

        // R2: exact latency of a single pair
        @(negedge clk);
        i_valid = 1'b1;
        i_dvd   = 32'h40400000;
        i_dvs   = 32'h40000000;
        lat = 0;
        for (int c = 1; c <= LAT + 4; c++) begin
            @(negedge clk);
            i_valid = 1'b0;
            if (o_valid && lat == 0) lat = c;
        end
        tally(lat == LAT, "R2", "cycles to o_valid", 35'(lat), 35'(LAT));

        // R1/R3/R5: table walked as one back-to-back stream
        for (int i = 0; i < NTBL; i++) begin
            sa[i] = TBL[i][63:32];
            sb[i] = TBL[i][31:0];
        end
        stream(NTBL, "R1 R3 R5 table");

        // R1/R3: divisor ramps up while dividend ramps down
        for (int k = 0; k < NRMP; k++) begin
            sb[k] = {1'b0, 8'(123 + k % 13), 23'(k * 1234567)};
            sa[k] = {1'b0, 8'(135 - k % 13), 23'(k * 7654321)};
        end
        stream(NRMP, "R1 R3 ramp");

        // R4: worked example
        issue1(32'h43FA0000, 32'h43340000);
        tally(res[30:23] == 8'd128, "R4", "exponent field of 500/180",
              35'(res[30:23]), 35'd128);
        chk_quo(32'h43FA0000, 32'h43340000, res, "R4");

        // R6: overflow, both signs
        issue1(32'h7F000000, 32'h3E800000);
        tally(res == {3'b100, 32'h7F800000}, "R6", "overflow to +inf", res,
              {3'b100, 32'h7F800000});
        issue1(32'hFF000000, 32'h3E800000);
        tally(res == {3'b100, 32'hFF800000}, "R6 R5", "overflow to -inf", res,
              {3'b100, 32'hFF800000});

        // R7: underflow, both signs
        issue1(32'h00800000, 32'h40800000);
        tally(res == {3'b010, 32'h00000000}, "R7", "underflow to +0", res,
              {3'b010, 32'h00000000});
        issue1(32'h80800000, 32'h40800000);
        tally(res == {3'b010, 32'h80000000}, "R7 R5", "underflow to -0", res,
              {3'b010, 32'h80000000});

        // R8: zero divisor, and its priority over zero dividend
        issue1(32'h40400000, 32'h80000000);
        tally(res == {3'b001, 32'hFF800000}, "R8", "3 / -0", res, {3'b001, 32'hFF800000});
        issue1(32'h00000000, 32'h00000000);
        tally(res == {3'b001, 32'h7F800000}, "R8", "0 / 0", res, {3'b001, 32'h7F800000});

        // R9: zero dividend
        issue1(32'h80000000, 32'h40400000);
        tally(res == {3'b000, 32'h80000000}, "R9", "-0 / 3", res, {3'b000, 32'h80000000});

        // R11 / R3 extremes: reciprocal alone outside normal range
        issue1(32'h7F000000, 32'h7F000000);
        chk_quo(32'h7F000000, 32'h7F000000, res, "R11");
        issue1(32'h00800000, 32'h00800000);
        chk_quo(32'h00800000, 32'h00800000, res, "R11 R3");

        // R12: flags low once the pipeline drains
        repeat (LAT + 2) @(negedge clk);
        tally({o_valid, o_ovf, o_unf, o_dz} == 4'd0, "R12", "flags idle",
              {31'd0, o_valid, o_ovf, o_unf, o_dz}, 35'd0);

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule